// File: doc/BRIEF.md
# Secured One-Time-Programmable Store Access Port

This block sits between an external programming port and a one-time-programmable byte store. The store holds three regions: a 1024-byte program area, a single option byte and an 8-byte area for user identification data. A 2-bit region select, an address, write data and read and write strobes drive each access. Read data comes back from a register one cycle later. A one-cycle flag reports any write that the block refuses.

One bit of the option byte locks the part. Once the lock is set, program bytes read back as all ones, and the program area and the option byte can no longer be written. The option byte stays readable and the user bytes stay fully open. An erase command clears the part, but only in builds marked erasable. Erase sets program and user bytes to all ones and clears the option byte except its lock bit. So a locked part that is erased stays locked and can no longer be programmed.

Top module: `otp_port`

## Requirements
- R1: After reset, rdData is 8'h00, wrRejected is 0, every program and user byte reads 8'hFF, and the option byte reads 8'h80 when ERASABLE=0 and 8'h00 when ERASABLE=1.
- R2: regionSel 2'b00 selects the program area (byte index = addr), 2'b01 the option byte and 2'b10 the user area (byte index = addr[2:0]). A read strobe loads rdData on the next clock edge. rdData holds its value while no read strobe is given.
- R3: While option bit 5 is 1 (locked), every read of the program area returns 8'hFF.
- R4: While locked, writes to the program area and to the option byte leave the stored values unchanged and raise wrRejected.
- R5: The option byte can be read in every lock state.
- R6: The user bytes can be read and written in every lock state, with no rejection.
- R7: Region 2'b11 reads as 8'h00, and a write to it is rejected.
- R8: When read and write strobes are asserted together, the read is served, the write is dropped and wrRejected stays low.
- R9: With ERASABLE=1, an erase sets all program and user bytes to 8'hFF and clears every option bit except bit 5. Strobes given in the erase cycle are ignored.
- R10: With ERASABLE=0, the erase input has no effect on any stored byte.
- R11: The lock bit, once set, never clears through writes or erase. After an erase, a locked part still rejects program and option writes.
- R12: wrRejected is high for exactly the one cycle after a rejected write strobe, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regionSel | input | 2 | Region select: 00 program, 01 option, 10 user, 11 reserved |
| addr | input | 10 | Byte address within the region |
| wrData | input | 8 | Data to write |
| rdStrobe | input | 1 | Read request |
| wrStrobe | input | 1 | Write request |
| eraseCmd | input | 1 | Erase request (acts only when ERASABLE=1) |
| rdData | output | 8 | Registered read result |
| wrRejected | output | 1 | One-cycle pulse for a refused write |

## Verification
Both results take exactly one register stage: rdData and wrRejected show the effect of a strobe right after the next rising edge. A write changes the store at that same edge, so a read issued in the following cycle already sees the new byte. The bench drives each access on a falling edge and samples both outputs on the next falling edge, which falls midway through the cycle in which they are due. It then drops the strobes so that the following cycle starts idle or with a fresh access. The effects of an erase are checked through ordinary reads in the cycles after the erase, on an erasable and a non-erasable instance driven in parallel.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    REGION_CODE = 2'b00,
    REGION_CFG  = 2'b01,
    REGION_USER = 2'b10,
    REGION_RSVD = 2'b11
  } region_e;

  typedef enum logic [2:0] {
    SEL_CODE,
    SEL_ONES,
    SEL_CFG,
    SEL_USER,
    SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   rdEn;
    rdSel_e rdSel;
    logic   wrCode;
    logic   wrCfg;
    logic   wrUser;
    logic   erase;
    logic   reject;
  } ctrl_t;

endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter bit ERASABLE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regionSel,
  input  logic       rdStrobe,
  input  logic       wrStrobe,
  input  logic       eraseCmd,
  input  logic       secured,
  output ctrl_t      ctl,
  output logic       wrRejected
);

  localparam logic ERASE_EN = ERASABLE;

  logic eraseGo;
  logic rdGo;
  logic wrGo;
  logic isCode, isCfg, isUser, isRsvd;
  logic rejectNow;

  assign eraseGo = eraseCmd & ERASE_EN;
  assign rdGo    = rdStrobe & ~eraseGo;
  assign wrGo    = wrStrobe & ~rdStrobe & ~eraseGo;

  assign isCode = (region_e'(regionSel) == REGION_CODE);
  assign isCfg  = (region_e'(regionSel) == REGION_CFG);
  assign isUser = (region_e'(regionSel) == REGION_USER);
  assign isRsvd = (region_e'(regionSel) == REGION_RSVD);

  assign rejectNow = wrGo & (isRsvd | (secured & (isCode | isCfg)));

  always_comb begin
    ctl        = '0;
    ctl.rdEn   = rdGo;
    ctl.erase  = eraseGo;
    ctl.wrCode = wrGo & isCode & ~secured;
    ctl.wrCfg  = wrGo & isCfg & ~secured;
    ctl.wrUser = wrGo & isUser;
    ctl.reject = rejectNow;
    unique case (1'b1)
      isCode:  ctl.rdSel = secured ? SEL_ONES : SEL_CODE;
      isCfg:   ctl.rdSel = SEL_CFG;
      isUser:  ctl.rdSel = SEL_USER;
      default: ctl.rdSel = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrRejected <= 1'b0;
    else       wrRejected <= ctl.reject;
  end

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int   CODE_BYTES = 1024,
  parameter int   USER_BYTES = 8,
  parameter int   DATA_W     = 8,
  parameter int   SEC_BIT    = 5,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h80
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrl_t                         ctl,
  input  logic [$clog2(CODE_BYTES)-1:0] addr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic                          secured
);

  localparam int CODE_AW = $clog2(CODE_BYTES);
  localparam int USER_AW = $clog2(USER_BYTES);
  localparam logic [DATA_W-1:0] BLANK    = '1;
  localparam logic [DATA_W-1:0] SEC_MASK = DATA_W'(1) << SEC_BIT;

  logic [DATA_W-1:0] codeMem [CODE_BYTES];
  logic [DATA_W-1:0] userMem [USER_BYTES];
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] rdNext;
  logic [CODE_AW-1:0] codeIdx;
  logic [USER_AW-1:0] userIdx;

  assign codeIdx = addr;
  assign userIdx = addr[USER_AW-1:0];
  assign secured = cfgReg[SEC_BIT];

  always_comb begin
    unique case (ctl.rdSel)
      SEL_CODE: rdNext = codeMem[codeIdx];
      SEL_ONES: rdNext = BLANK;
      SEL_CFG:  rdNext = cfgReg;
      SEL_USER: rdNext = userMem[userIdx];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CODE_BYTES; i++) codeMem[i] <= BLANK;
      for (int j = 0; j < USER_BYTES; j++) userMem[j] <= BLANK;
      cfgReg <= CFG_RESET;
      rdData <= '0;
    end else if (ctl.erase) begin
      for (int i = 0; i < CODE_BYTES; i++) codeMem[i] <= BLANK;
      for (int j = 0; j < USER_BYTES; j++) userMem[j] <= BLANK;
      cfgReg <= cfgReg & SEC_MASK;
    end else begin
      if (ctl.wrCode) codeMem[codeIdx] <= wrData;
      if (ctl.wrUser) userMem[userIdx] <= wrData;
      if (ctl.wrCfg)  cfgReg <= wrData;
      if (ctl.rdEn)   rdData <= rdNext;
    end
  end

endmodule

// File: rtl/otp_port.sv
module otp_port
  import otp_pkg::*;
#(
  parameter int CODE_BYTES = 1024,
  parameter int USER_BYTES = 8,
  parameter int DATA_W     = 8,
  parameter int SEC_BIT    = 5,
  parameter bit ERASABLE   = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    regionSel,
  input  logic [$clog2(CODE_BYTES)-1:0] addr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          rdStrobe,
  input  logic                          wrStrobe,
  input  logic                          eraseCmd,
  output logic [DATA_W-1:0]             rdData,
  output logic                          wrRejected
);

  localparam logic [DATA_W-1:0] CFG_RESET = ERASABLE ? DATA_W'(0) : DATA_W'(8'h80);

  ctrl_t ctl;
  logic  secured;

  otp_ctrl #(.ERASABLE(ERASABLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .regionSel(regionSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .eraseCmd(eraseCmd), .secured(secured),
    .ctl(ctl), .wrRejected(wrRejected)
  );

  otp_store #(
    .CODE_BYTES(CODE_BYTES), .USER_BYTES(USER_BYTES), .DATA_W(DATA_W),
    .SEC_BIT(SEC_BIT), .CFG_RESET(CFG_RESET)
  ) store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .wrData(wrData),
    .rdData(rdData), .secured(secured)
  );

endmodule

// File: rtl/otp_port_chk.sv
module otp_port_chk #(
  parameter int DATA_W   = 8,
  parameter bit ERASABLE = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regionSel,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic              eraseCmd,
  input logic              secured,
  input logic [DATA_W-1:0] rdData,
  input logic              wrRejected
);

  logic eraseAct;
  assign eraseAct = eraseCmd & ERASABLE;

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    secured |=> secured);

  assert_reject_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    wrRejected |-> $past(wrStrobe && !rdStrobe));

  assert_locked_code_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && regionSel == 2'b00 && secured && !eraseAct) |=> (rdData == '1));

  assert_rsvd_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && regionSel == 2'b11 && !eraseAct) |=> (rdData == '0));

  assert_rsvd_write_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !rdStrobe && regionSel == 2'b11 && !eraseAct) |=> wrRejected);

  assert_rdwr_no_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && wrStrobe) |=> !wrRejected);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));

  assert_user_write_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !rdStrobe && regionSel == 2'b10) |=> !wrRejected);

endmodule

bind otp_port otp_port_chk #(.DATA_W(DATA_W), .ERASABLE(ERASABLE)) chk_i (
  .clk(clk), .rstN(rstN), .regionSel(regionSel), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .eraseCmd(eraseCmd), .secured(secured),
  .rdData(rdData), .wrRejected(wrRejected)
);

// File: tb/otp_port_tb.sv
module otp_port_tb_top;

  typedef struct packed {
    logic [1:0] rg;
    logic [9:0] ad;
    logic [7:0] dt;
    logic       rd;
    logic       wr;
    logic [7:0] expRd;
    logic       expRej;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 10'd5,    8'hA5, 1'b0, 1'b1, 8'h00, 1'b0, 4'd2},  // R2 write code
    '{2'd0, 10'd5,    8'h00, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd2},  // R2 read back
    '{2'd2, 10'd2,    8'h3C, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 user write
    '{2'd2, 10'd2,    8'h00, 1'b1, 1'b0, 8'h3C, 1'b0, 4'd6},  // R6 user read
    '{2'd3, 10'd0,    8'h12, 1'b0, 1'b1, 8'h00, 1'b1, 4'd7},  // R7 reserved write
    '{2'd3, 10'd0,    8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd7},  // R7 reserved read
    '{2'd0, 10'd5,    8'h11, 1'b1, 1'b1, 8'hA5, 1'b0, 4'd8},  // R8 rd+wr
    '{2'd0, 10'd5,    8'h00, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd8},  // R8 write dropped
    '{2'd0, 10'd1023, 8'h5A, 1'b0, 1'b1, 8'h00, 1'b0, 4'd2},  // R2 top address
    '{2'd0, 10'd1023, 8'h00, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd2},  // R2
    '{2'd0, 10'd6,    8'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 4'd1},  // R1 blank byte
    '{2'd1, 10'd0,    8'h01, 1'b0, 1'b1, 8'h00, 1'b0, 4'd5},  // R5 option write
    '{2'd1, 10'd0,    8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 4'd5},  // R5
    '{2'd1, 10'd0,    8'h21, 1'b0, 1'b1, 8'h00, 1'b0, 4'd11}, // R11 set lock
    '{2'd1, 10'd0,    8'h00, 1'b1, 1'b0, 8'h21, 1'b0, 4'd5},  // R5 read when locked
    '{2'd0, 10'd5,    8'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 4'd3},  // R3 locked read
    '{2'd0, 10'd5,    8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 4'd4},  // R4 code write refused
    '{2'd1, 10'd0,    8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 4'd4},  // R4 option write refused
    '{2'd1, 10'd0,    8'h00, 1'b1, 1'b0, 8'h21, 1'b0, 4'd11}, // R11 lock kept
    '{2'd2, 10'd2,    8'h77, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 user write locked
    '{2'd2, 10'd2,    8'h00, 1'b1, 1'b0, 8'h77, 1'b0, 4'd6}   // R6
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regionSel = '0;
  logic [9:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       rdStrobe = 1'b0, wrStrobe = 1'b0, eraseCmd = 1'b0;
  logic [7:0] rdA, rdE;
  logic       rejA, rejE;
  logic [7:0] gotRdA, gotRdE;
  logic       gotRejA, gotRejE;
  int         nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  otp_port dut_i (
    .clk(clk), .rstN(rstN), .regionSel(regionSel), .addr(addr), .wrData(wrData),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .eraseCmd(eraseCmd),
    .rdData(rdA), .wrRejected(rejA)
  );

  otp_port #(.ERASABLE(1'b1)) dutEr_i (
    .clk(clk), .rstN(rstN), .regionSel(regionSel), .addr(addr), .wrData(wrData),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .eraseCmd(eraseCmd),
    .rdData(rdE), .wrRejected(rejE)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] rg, input logic [9:0] ad, input logic [7:0] dt,
                    input logic rd, input logic wr, input logic er);
    regionSel = rg; addr = ad; wrData = dt;
    rdStrobe = rd; wrStrobe = wr; eraseCmd = er;
    @(negedge clk);
    gotRdA = rdA; gotRdE = rdE; gotRejA = rejA; gotRejE = rejE;
    rdStrobe = 1'b0; wrStrobe = 1'b0; eraseCmd = 1'b0;
  endtask

  task automatic runRows(input int lo, input int hi);
    for (int k = lo; k <= hi; k++) begin
      string tg;
      vec_t v = VEC[k];
      tg = $sformatf("R%0d row%0d", v.req, k);
      op(v.rg, v.ad, v.dt, v.rd, v.wr, 1'b0);
      if (v.rd) begin
        check8({tg, " rdData"}, gotRdA, v.expRd);
        check8({tg, " rdData erasable"}, gotRdE, v.expRd);
      end
      check8({tg, " wrRejected"}, {7'd0, gotRejA}, {7'd0, v.expRej});
      check8({tg, " wrRejected erasable"}, {7'd0, gotRejE}, {7'd0, v.expRej});
    end
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check8("R1 rdData after reset", rdA, 8'h00);
    check8("R1 wrRejected after reset", {7'd0, rejA}, 8'h00);
    op(2'd1, 10'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R1 option reset one-time", gotRdA, 8'h80);
    check8("R1 option reset erasable", gotRdE, 8'h00);
    op(2'd0, 10'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R1 code blank", gotRdA, 8'hFF);
    op(2'd2, 10'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R1 user blank", gotRdA, 8'hFF);
    // R2: rdData holds without a read strobe
    op(2'd0, 10'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    check8("R2 rdData held", gotRdA, 8'hFF);

    runRows(0, 10);

    // R9 / R10 erase while unlocked; a read in the erase cycle is ignored
    op(2'd3, 10'd0, 8'h00, 1'b1, 1'b0, 1'b1);
    check8("R9 read ignored during erase", gotRdE, 8'hFF);
    op(2'd0, 10'd5, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R10 code kept", gotRdA, 8'hA5);
    check8("R9 code erased", gotRdE, 8'hFF);
    op(2'd0, 10'd1023, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R10 top code kept", gotRdA, 8'h5A);
    check8("R9 top code erased", gotRdE, 8'hFF);
    op(2'd2, 10'd2, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R10 user kept", gotRdA, 8'h3C);
    check8("R9 user erased", gotRdE, 8'hFF);
    op(2'd1, 10'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R10 option kept", gotRdA, 8'h80);
    check8("R9 option cleared", gotRdE, 8'h00);

    runRows(11, 20);

    // R9 / R11 erase while locked
    op(2'd0, 10'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    op(2'd1, 10'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R10 option kept locked", gotRdA, 8'h21);
    check8("R11 lock survives erase", gotRdE, 8'h20);
    op(2'd2, 10'd2, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R10 user kept locked", gotRdA, 8'h77);
    check8("R9 user erased locked", gotRdE, 8'hFF);
    op(2'd0, 10'd9, 8'h00, 1'b0, 1'b1, 1'b0);
    check8("R11 erased locked part refuses code write", {7'd0, gotRejE}, 8'h01);
    // R12 pulse lasts one cycle
    op(2'd0, 10'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    check8("R12 pulse ends", {7'd0, gotRejE}, 8'h00);
    check8("R12 pulse ends one-time", {7'd0, gotRejA}, 8'h00);
    op(2'd1, 10'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check8("R11 option unchanged after refused writes", gotRdE, 8'h20);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule